// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block forms the memory address for load and store instructions in a register-based machine where only loads and stores touch memory. It receives the base register contents, an offset source and a few control fields from decode. It returns the effective address and, when the indexing mode asks for it, a new value for the base register. The offset is either a short unsigned immediate or a second register value passed through a barrel shifter. The shifter supports logical left, logical right, arithmetic right, rotate right and rotate-through-carry, with the shift count coming from an instruction immediate. Its carry-out is exposed for the flags logic.

An up/down bit chooses whether the offset is added to or subtracted from the base. Three indexing modes are supported. Plain offset mode uses base±offset and leaves the base alone. Pre-index mode uses base±offset and also writes it back. Post-index mode uses the untouched base as the address and writes base±offset back. A separate path computes branch targets: a signed 24-bit word offset is scaled by four and added to the PC value. All results appear at a registered output stage one cycle after a valid input.

Top module: `agu_ls_top`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid, addr, wb_en, wb_val and shift_cout are all 0.
- R2: out_valid equals in_valid from the previous clock. When in_valid was low, addr, wb_en, wb_val and shift_cout hold their previous values.
- R3: With is_branch=0 and idx_mode 2'b00 or 2'b11 (offset mode), addr is base_val±offset and wb_en is 0.
- R4: With is_branch=0 and idx_mode 2'b01 (pre-index), addr and wb_val both equal base_val±offset, and wb_en is 1.
- R5: With is_branch=0 and idx_mode 2'b10 (post-index), addr equals base_val, wb_val equals base_val±offset, and wb_en is 1.
- R6: add_sub=1 adds the offset and add_sub=0 subtracts it, both modulo 2^32.
- R7: With use_reg=0, the offset is imm_off (12 bits) zero-extended, and shift_cout equals carry_in.
- R8: With use_reg=1 and shift_op 2'b00 (shift left), a count n>0 gives off_reg<<n with carry-out off_reg bit 32-n. A count of 0 passes off_reg unchanged, and the carry-out is carry_in.
- R9: With shift_op 2'b01 (logical right), a count n>0 gives off_reg>>n with carry-out bit n-1. A count of 0 means a shift by 32: the result is 0 and the carry-out is bit 31.
- R10: With shift_op 2'b10 (arithmetic right), a count n>0 shifts in copies of bit 31 with carry-out bit n-1. A count of 0 fills all 32 bits with bit 31, and the carry-out is bit 31.
- R11: With shift_op 2'b11 (rotate right), a count n>0 rotates right by n with carry-out bit n-1. A count of 0 rotates right by one through the carry: carry_in enters bit 31 and the carry-out is old bit 0.
- R12: With is_branch=1, addr is pc_val plus the sign-extended br_off times 4 (modulo 2^32), wb_en is 0 and wb_val is 0, whatever idx_mode is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| is_branch | input | 1 | Compute a branch target instead of a data address |
| idx_mode | input | 2 | 00/11 offset, 01 pre-index, 10 post-index |
| add_sub | input | 1 | 1 add offset, 0 subtract offset |
| use_reg | input | 1 | 1 shifted register offset, 0 immediate offset |
| shift_op | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR/RRX |
| shift_amt | input | 5 | Shift count from the instruction |
| carry_in | input | 1 | Current carry flag |
| base_val | input | 32 | Base register contents |
| off_reg | input | 32 | Offset register contents |
| imm_off | input | 12 | Unsigned immediate offset |
| pc_val | input | 32 | PC value for branch targets |
| br_off | input | 24 | Signed word offset for branches |
| out_valid | output | 1 | Registered result valid |
| addr | output | 32 | Memory address or branch target |
| wb_en | output | 1 | Base register writeback request |
| wb_val | output | 32 | Value to write back to the base |
| shift_cout | output | 1 | Shifter carry-out |

## Verification
A wrong shifter case shows up at addr and shift_cout one cycle after the stimulus. The sweep crosses every shift operation with every count, including the count-zero encodings, and several bit patterns. A swapped indexing mode shows at once as a wrong address or writeback pair in that same cycle: post-index would return base±offset, or offset mode would raise wb_en. A sign or scaling error on the branch path is exposed by the extreme positive and negative word offsets. A broken output register shows up one cycle after in_valid drops, as changing outputs or out_valid left high.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } shift_op_e;

   typedef enum logic [1:0] {
      IX_OFFSET = 2'b00,
      IX_PRE    = 2'b01,
      IX_POST   = 2'b10,
      IX_OFFALT = 2'b11
   } idx_mode_e;
endpackage

// File: rtl/agu_shift.sv
module agu_shift
   import agu_pkg::*;
#(
   parameter int DW   = 32,
   localparam int SA_W = $clog2(DW)
) (
   input  logic [DW-1:0]   val,
   input  logic [SA_W-1:0] amt,
   input  shift_op_e       op,
   input  logic            cin,
   output logic [DW-1:0]   res,
   output logic            cout
);
   logic [SA_W-1:0] amt_m1;
   logic [SA_W-1:0] amt_neg;
   logic [2*DW-1:0] rot_dbl;
   logic            amt_zero;

   assign amt_zero = (amt == '0);
   assign amt_m1   = amt - 1'b1;
   assign amt_neg  = SA_W'(0) - amt;
   assign rot_dbl  = {val, val} >> amt;

   always_comb begin
      res  = val;
      cout = cin;
      unique case (op)
         SH_LSL: begin
            if (!amt_zero) begin
               res  = val << amt;
               cout = val[amt_neg];
            end
         end
         SH_LSR: begin
            if (amt_zero) begin
               res  = '0;
               cout = val[DW-1];
            end else begin
               res  = val >> amt;
               cout = val[amt_m1];
            end
         end
         SH_ASR: begin
            if (amt_zero) begin
               res  = {DW{val[DW-1]}};
               cout = val[DW-1];
            end else begin
               res  = DW'($signed(val) >>> amt);
               cout = val[amt_m1];
            end
         end
         SH_ROR: begin
            if (amt_zero) begin
               res  = {cin, val[DW-1:1]};
               cout = val[0];
            end else begin
               res  = rot_dbl[DW-1:0];
               cout = val[amt_m1];
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/agu_index.sv
module agu_index
   import agu_pkg::*;
#(
   parameter int DW    = 32,
   parameter int IMM_W = 12
) (
   input  logic [DW-1:0]    base,
   input  logic [DW-1:0]    reg_off,
   input  logic [IMM_W-1:0] imm,
   input  logic             use_reg,
   input  logic             add_sub,
   input  idx_mode_e        mode,
   output logic [DW-1:0]    ea,
   output logic             wb_en,
   output logic [DW-1:0]    wb_val
);
   localparam int PAD_W = DW - IMM_W;

   logic [DW-1:0] off;
   logic [DW-1:0] moved;

   assign off   = use_reg ? reg_off : {{PAD_W{1'b0}}, imm};
   assign moved = add_sub ? (base + off) : (base - off);

   always_comb begin
      ea     = moved;
      wb_en  = 1'b0;
      wb_val = moved;
      unique case (mode)
         IX_PRE:  wb_en = 1'b1;
         IX_POST: begin
            ea    = base;
            wb_en = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/agu_branch.sv
module agu_branch #(
   parameter int DW   = 32,
   parameter int BR_W = 24
) (
   input  logic [DW-1:0]   pc,
   input  logic [BR_W-1:0] woff,
   output logic [DW-1:0]   target
);
   localparam int EXT_W = DW - BR_W - 2;

   logic [DW-1:0] byte_off;

   assign byte_off = {{EXT_W{woff[BR_W-1]}}, woff, 2'b00};
   assign target   = pc + byte_off;
endmodule

// File: rtl/agu_ls_top.sv
module agu_ls_top
   import agu_pkg::*;
#(
   parameter int DW    = 32,
   parameter int IMM_W = 12,
   parameter int BR_W  = 24,
   localparam int SA_W = $clog2(DW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             is_branch,
   input  logic [1:0]       idx_mode,
   input  logic             add_sub,
   input  logic             use_reg,
   input  logic [1:0]       shift_op,
   input  logic [SA_W-1:0]  shift_amt,
   input  logic             carry_in,
   input  logic [DW-1:0]    base_val,
   input  logic [DW-1:0]    off_reg,
   input  logic [IMM_W-1:0] imm_off,
   input  logic [DW-1:0]    pc_val,
   input  logic [BR_W-1:0]  br_off,
   output logic             out_valid,
   output logic [DW-1:0]    addr,
   output logic             wb_en,
   output logic [DW-1:0]    wb_val,
   output logic             shift_cout
);
   if (DW < 8 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("agu_ls_top: DW must be a power of two of at least 8");
   end
   if (IMM_W < 1 || IMM_W >= DW) begin : g_bad_imm
      $error("agu_ls_top: IMM_W must lie in 1..DW-1");
   end
   if (BR_W < 1 || BR_W + 2 >= DW) begin : g_bad_br
      $error("agu_ls_top: BR_W + 2 must be below DW");
   end

   logic [DW-1:0] sh_res;
   logic          sh_cout;
   logic [DW-1:0] ix_ea;
   logic          ix_wb_en;
   logic [DW-1:0] ix_wb_val;
   logic [DW-1:0] br_tgt;

   agu_shift #(.DW(DW)) u_shift (
      .val  (off_reg),
      .amt  (shift_amt),
      .op   (shift_op_e'(shift_op)),
      .cin  (carry_in),
      .res  (sh_res),
      .cout (sh_cout)
   );

   agu_index #(.DW(DW), .IMM_W(IMM_W)) u_index (
      .base    (base_val),
      .reg_off (sh_res),
      .imm     (imm_off),
      .use_reg (use_reg),
      .add_sub (add_sub),
      .mode    (idx_mode_e'(idx_mode)),
      .ea      (ix_ea),
      .wb_en   (ix_wb_en),
      .wb_val  (ix_wb_val)
   );

   agu_branch #(.DW(DW), .BR_W(BR_W)) u_branch (
      .pc     (pc_val),
      .woff   (br_off),
      .target (br_tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         addr       <= '0;
         wb_en      <= 1'b0;
         wb_val     <= '0;
         shift_cout <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            addr       <= is_branch ? br_tgt : ix_ea;
            wb_en      <= ix_wb_en & ~is_branch;
            wb_val     <= is_branch ? '0 : ix_wb_val;
            shift_cout <= use_reg ? sh_cout : carry_in;
         end
      end
   end
endmodule

// File: rtl/agu_ls_chk.sv
module agu_ls_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          is_branch,
   input logic [1:0]    idx_mode,
   input logic [DW-1:0] base_val,
   input logic [DW-1:0] pc_val,
   input logic          out_valid,
   input logic [DW-1:0] addr,
   input logic          wb_en,
   input logic [DW-1:0] wb_val
);
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid)) |-> out_valid);

   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> (!out_valid && $stable(addr) && $stable(wb_val)));

   p_offset_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && !$past(is_branch)
       && ($past(idx_mode) == 2'b00 || $past(idx_mode) == 2'b11)) |-> !wb_en);

   p_pre_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && !$past(is_branch) && $past(idx_mode) == 2'b01)
      |-> (wb_en && wb_val == addr));

   p_post_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && !$past(is_branch) && $past(idx_mode) == 2'b10)
      |-> (wb_en && addr == $past(base_val)));

   p_branch_no_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && $past(is_branch))
      |-> (!wb_en && addr[1:0] == $past(pc_val[1:0])));
endmodule

bind agu_ls_top agu_ls_chk #(.DW(DW)) u_chk (.*);

// File: tb/agu_ls_top_test.sv
module agu_ls_top_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_branch = 1'b0;
   logic [1:0]  idx_mode = '0;
   logic        add_sub = 1'b1;
   logic        use_reg = 1'b0;
   logic [1:0]  shift_op = '0;
   logic [4:0]  shift_amt = '0;
   logic        carry_in = 1'b0;
   logic [31:0] base_val = '0;
   logic [31:0] off_reg = '0;
   logic [11:0] imm_off = '0;
   logic [31:0] pc_val = '0;
   logic [23:0] br_off = '0;
   logic        out_valid;
   logic [31:0] addr;
   logic        wb_en;
   logic [31:0] wb_val;
   logic        shift_cout;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   agu_ls_top uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_branch(is_branch),
      .idx_mode(idx_mode), .add_sub(add_sub), .use_reg(use_reg),
      .shift_op(shift_op), .shift_amt(shift_amt), .carry_in(carry_in),
      .base_val(base_val), .off_reg(off_reg), .imm_off(imm_off),
      .pc_val(pc_val), .br_off(br_off), .out_valid(out_valid), .addr(addr),
      .wb_en(wb_en), .wb_val(wb_val), .shift_cout(shift_cout)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // bit-serial reference shifter: returns {carry, result}
   function automatic logic [32:0] ref_shift(input logic [1:0] op, input int amt,
                                             input logic [31:0] v, input logic cin);
      logic [31:0] r = v;
      logic        c = cin;
      int          n;
      case (op)
         2'd0: for (int i = 0; i < amt; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
         2'd1: begin
            n = (amt == 0) ? 32 : amt;
            for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[31:1]}; end
         end
         2'd2: begin
            n = (amt == 0) ? 32 : amt;
            for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
         end
         default: begin
            if (amt == 0) begin c = r[0]; r = {cin, r[31:1]}; end
            else for (int i = 0; i < amt; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
         end
      endcase
      return {c, r};
   endfunction

   task automatic issue;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] vals [4];
      logic [31:0] bases [3];
      logic [31:0] offs [3];
      logic [32:0] r;
      logic [31:0] sum;
      logic [31:0] tgt;
      logic [23:0] brs [5];
      logic [31:0] pcs [2];
      string       tg;
      vals  = '{32'h8000_0001, 32'h7F00_00FE, 32'hA5A5_5A5A, 32'h0000_0000};
      bases = '{32'h0000_1000, 32'h0000_0000, 32'hFFFF_FFF0};
      offs  = '{32'h0000_0010, 32'h0000_0001, 32'h1234_5678};
      brs   = '{24'h000000, 24'h000001, 24'hFFFFFF, 24'h7FFFFF, 24'h800000};
      pcs   = '{32'h0000_8000, 32'hFFFF_FFFC};

      // R1: reset state, even with in_valid driven high
      in_valid = 1'b1; base_val = 32'hDEAD_BEEF; carry_in = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1", "addr", addr, 32'd0);
      chk("R1", "wb_en", {31'd0, wb_en}, 32'd0);
      chk("R1", "wb_val", wb_val, 32'd0);
      chk("R1", "shift_cout", {31'd0, shift_cout}, 32'd0);
      in_valid = 1'b0; carry_in = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R8..R11: shifter sweep, base 0, add, offset mode
      use_reg = 1'b1; base_val = '0; idx_mode = 2'b00; add_sub = 1'b1;
      for (int op = 0; op < 4; op++)
         for (int a = 0; a < 32; a++)
            for (int vi = 0; vi < 4; vi++)
               for (int ci = 0; ci < 2; ci++) begin
                  shift_op = 2'(op); shift_amt = 5'(a);
                  off_reg = vals[vi]; carry_in = 1'(ci);
                  issue();
                  r = ref_shift(2'(op), a, vals[vi], 1'(ci));
                  tg = (op == 0) ? "R8" : (op == 1) ? "R9" : (op == 2) ? "R10" : "R11";
                  chk(tg, "shift addr", addr, r[31:0]);
                  chk(tg, "shift cout", {31'd0, shift_cout}, {31'd0, r[32]});
                  chk("R2", "out_valid", {31'd0, out_valid}, 32'd1);
               end

      // R3..R6: index modes with add and subtract
      shift_op = 2'b00; shift_amt = 5'd0;
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int bi = 0; bi < 3; bi++)
               for (int oi = 0; oi < 3; oi++) begin
                  idx_mode = 2'(m); add_sub = 1'(s);
                  base_val = bases[bi]; off_reg = offs[oi];
                  issue();
                  sum = s ? bases[bi] + offs[oi] : bases[bi] - offs[oi];
                  if (m == 1) begin
                     chk("R4", "pre addr", addr, sum);
                     chk("R4", "pre wb_val", wb_val, sum);
                     chk("R4", "pre wb_en", {31'd0, wb_en}, 32'd1);
                  end else if (m == 2) begin
                     chk("R5", "post addr", addr, bases[bi]);
                     chk("R5", "post wb_val", wb_val, sum);
                     chk("R5", "post wb_en", {31'd0, wb_en}, 32'd1);
                  end else begin
                     chk("R3", "offset addr", addr, sum);
                     chk("R3", "offset wb_en", {31'd0, wb_en}, 32'd0);
                  end
                  if (s == 0) chk("R6", "subtract result", wb_val, sum);
               end

      // R6: subtract wraps below zero
      idx_mode = 2'b01; add_sub = 1'b0; base_val = 32'd0; off_reg = 32'd1;
      issue();
      chk("R6", "wrap addr", addr, 32'hFFFF_FFFF);

      // R7: immediate offset zero-extended, carry passes through
      use_reg = 1'b0; off_reg = 32'hFFFF_FFFF; shift_op = 2'b01;
      for (int ci = 0; ci < 2; ci++)
         for (int s = 0; s < 2; s++) begin
            idx_mode = 2'b00; add_sub = 1'(s); carry_in = 1'(ci);
            base_val = 32'h0001_0000; imm_off = 12'hFFF;
            issue();
            chk("R7", "imm addr", addr, s ? 32'h0001_0FFF : 32'h0000_F001);
            chk("R7", "imm cout", {31'd0, shift_cout}, {31'd0, 1'(ci)});
         end

      // R12: branch targets override index mode
      is_branch = 1'b1; use_reg = 1'b1;
      for (int pi = 0; pi < 2; pi++)
         for (int b = 0; b < 5; b++) begin
            idx_mode = 2'(b % 4); pc_val = pcs[pi]; br_off = brs[b];
            issue();
            tgt = pcs[pi] + 32'($signed({{6{brs[b][23]}}, brs[b], 2'b00}));
            chk("R12", "branch addr", addr, tgt);
            chk("R12", "branch wb_en", {31'd0, wb_en}, 32'd0);
            chk("R12", "branch wb_val", wb_val, 32'd0);
         end
      is_branch = 1'b0;

      // R2: outputs hold while in_valid is low
      idx_mode = 2'b10; add_sub = 1'b1; base_val = 32'h0000_4000; off_reg = 32'h8;
      shift_op = 2'b00; shift_amt = 5'd0;
      issue();
      chk("R2", "setup addr", addr, 32'h0000_4000);
      base_val = 32'h1111_1111; off_reg = 32'h2222_2222; idx_mode = 2'b01;
      @(negedge clk);
      chk("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
      chk("R2", "idle addr", addr, 32'h0000_4000);
      chk("R2", "idle wb_val", wb_val, 32'h0000_4008);
      chk("R2", "idle wb_en", {31'd0, wb_en}, 32'd1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule